// File: doc/BRIEF.md
# Multi-word level-1 interrupt controller

This block gathers a configurable number of 32-bit words of level-sensitive interrupt sources and presents them to several CPUs. Each CPU owns an independent bank of mask bits over the same shared source inputs. Each CPU receives one parent interrupt line, which is raised while any source that is unmasked in its bank is active. A source is steered to a single CPU by clearing its mask bit in that CPU's bank only.

Software reaches the block through a simple register port. A CPU index selects one of the per-CPU register windows. A byte offset selects a register inside that window. A window holds four groups of `NUM_WORDS` registers each. In address order these are the raw source status, the current mask value, a write-one-to-set mask strobe and a write-one-to-clear mask strobe. The mask therefore never needs a read-modify-write. Reads return data one clock after the request.

Top module: `lvl1_irq_agg`

## Requirements
- R1: While reset is held and after its release, every mask bit of every bank is 1, `cpu_irq_o` is 0 and `rd_valid` is 0.
- R2: A status register returns the source inputs for its word as captured on the previous clock edge, with bit b of word w being `src_i[32*w+b]`. Writes to status offsets change nothing.
- R3: Within a window, word w of group g sits at byte offset (g*NUM_WORDS + w)*4. Group 0 is status, 1 is mask status, 2 is mask set and 3 is mask clear.
- R4: A write to a mask set register ORs the written value into that word of the selected CPU's bank and leaves the other bits as they were.
- R5: A write to a mask clear register clears the bits of that word of the selected CPU's bank where the written value is 1 and leaves the other bits as they were.
- R6: A mask status register reads back the current mask word of the selected CPU's bank. Writes to mask status offsets change nothing.
- R7: `cpu_irq_o[c]` is 1 exactly when some word has a status bit set with the matching mask bit of bank c at 0. It follows a status or mask change one clock later.
- R8: A mask write through the window of one CPU leaves every other CPU's bank and parent interrupt unchanged.
- R9: Offsets at or above NUM_WORDS*16, and offsets whose low two bits are not 00, are unmapped. Reads of them return 0 and writes to them change nothing.
- R10: `rd_valid` is 1 in exactly the cycle after a read request and carries `rd_data` for it. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_WORDS*32 | Level-sensitive interrupt sources |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_cpu | input | CPU_W | Index of the CPU window accessed |
| bus_addr | input | ADDR_W | Byte offset inside the window |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid, one cycle after a read request |
| rd_data | output | 32 | Read data |
| cpu_irq_o | output | NUM_CPUS | Parent interrupt, one per CPU |

## Verification
The assertions assume that `rst_n` is released between clock edges. They also assume that the mask state moves only in cycles that carry a write request, so the port must not be driven with glitches or half-formed requests. The stimulus changes every input half a cycle away from the rising edge. It holds `bus_sel` for exactly one cycle per access and drops it between accesses. It keeps `bus_cpu` inside the configured CPU count, so only the offset decides whether an access is mapped.

// File: rtl/lvl1_irq_pkg.sv
package lvl1_irq_pkg;
  localparam int WORD_BITS = 32;
  localparam int NUM_GROUPS = 4;

  typedef logic [WORD_BITS-1:0] word_t;

  // group order inside a window is part of the address map
  typedef enum logic [1:0] {
    GRP_STATUS = 2'd0,
    GRP_MSTAT  = 2'd1,
    GRP_MSET   = 2'd2,
    GRP_MCLR   = 2'd3
  } grp_e;
endpackage

// File: rtl/lvl1_src_capture.sv
module lvl1_src_capture
  import lvl1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_WORDS*WORD_BITS-1:0]       src_i,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  status_q
);
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] status_d;

  always_comb begin
    status_d = src_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/lvl1_reg_decode.sv
module lvl1_reg_decode
  import lvl1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  parameter int CPU_W     = 1,
  parameter int WSEL_W    = 2
) (
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [CPU_W-1:0]    bus_cpu,
  input  logic [ADDR_W-1:0]   bus_addr,
  output logic [NUM_CPUS-1:0] set_en,
  output logic [NUM_CPUS-1:0] clr_en,
  output logic                rd_en,
  output logic                rd_hit,
  output grp_e                grp,
  output logic [WSEL_W-1:0]   wsel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             hit;
  logic             cpu_ok;

  always_comb begin
    idx     = bus_addr[ADDR_W-1:2];
    aligned = (bus_addr[1:0] == 2'b00);
    hit     = 1'b0;
    grp     = GRP_STATUS;
    wsel    = '0;
    // linear compare against every legal register index
    for (int g = 0; g < NUM_GROUPS; g++) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (int'(idx) == g * NUM_WORDS + w) begin
          hit  = aligned;
          grp  = grp_e'(g[1:0]);
          wsel = w[WSEL_W-1:0];
        end
      end
    end
    cpu_ok = (int'(bus_cpu) < NUM_CPUS);
    rd_en  = bus_sel & ~bus_wr;
    rd_hit = rd_en & hit & cpu_ok;
  end

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu_wr
    logic mine;
    assign mine      = bus_sel & bus_wr & hit & (bus_cpu == CPU_W'(c));
    assign set_en[c] = mine & (grp == GRP_MSET);
    assign clr_en[c] = mine & (grp == GRP_MCLR);
  end
endmodule

// File: rtl/lvl1_mask_bank.sv
module lvl1_mask_bank
  import lvl1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int WSEL_W    = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 set_en,
  input  logic                                 clr_en,
  input  logic [WSEL_W-1:0]                    wsel,
  input  word_t                                wdata,
  output logic [NUM_WORDS-1:0][WORD_BITS-1:0]  mask_q
);
  logic [NUM_WORDS-1:0][WORD_BITS-1:0] mask_d;
  logic                                wr_en;

  always_comb begin
    mask_d = mask_q;
    wr_en  = set_en | clr_en;
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (wsel == WSEL_W'(w)) begin
        if (set_en) mask_d[w] = mask_d[w] | wdata;
        if (clr_en) mask_d[w] = mask_d[w] & ~wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= '1;
    else if (wr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/lvl1_irq_reduce.sv
module lvl1_irq_reduce
  import lvl1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2
) (
  input  logic                                               clk,
  input  logic                                               rst_n,
  input  logic [NUM_WORDS-1:0][WORD_BITS-1:0]                status,
  input  logic [NUM_CPUS-1:0][NUM_WORDS-1:0][WORD_BITS-1:0]  masks,
  output logic [NUM_CPUS-1:0]                                irq_q
);
  logic [NUM_CPUS-1:0] irq_d;

  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      irq_d[c] = |(status & ~masks[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end
endmodule

// File: rtl/lvl1_irq_agg.sv
module lvl1_irq_agg
  import lvl1_irq_pkg::*;
#(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2,
  parameter int ADDR_W    = 8,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int NUM_SRC  = NUM_WORDS * WORD_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [CPU_W-1:0]    bus_cpu,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic                rd_valid,
  output logic [31:0]         rd_data,
  output logic [NUM_CPUS-1:0] cpu_irq_o
);
  localparam int WSEL_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  logic [NUM_WORDS-1:0][WORD_BITS-1:0]               status_w;
  logic [NUM_CPUS-1:0][NUM_WORDS-1:0][WORD_BITS-1:0] masks;
  logic [NUM_CPUS-1:0]                               set_en;
  logic [NUM_CPUS-1:0]                               clr_en;
  logic                                              rd_en;
  logic                                              rd_hit;
  grp_e                                              grp;
  logic [WSEL_W-1:0]                                 wsel;
  word_t                                             rd_data_d;

  lvl1_src_capture #(.NUM_WORDS(NUM_WORDS)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_i    (src_i),
    .status_q (status_w)
  );

  lvl1_reg_decode #(
    .NUM_WORDS (NUM_WORDS),
    .NUM_CPUS  (NUM_CPUS),
    .ADDR_W    (ADDR_W),
    .CPU_W     (CPU_W),
    .WSEL_W    (WSEL_W)
  ) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_cpu  (bus_cpu),
    .bus_addr (bus_addr),
    .set_en   (set_en),
    .clr_en   (clr_en),
    .rd_en    (rd_en),
    .rd_hit   (rd_hit),
    .grp      (grp),
    .wsel     (wsel)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bank
    lvl1_mask_bank #(.NUM_WORDS(NUM_WORDS), .WSEL_W(WSEL_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en[c]),
      .clr_en (clr_en[c]),
      .wsel   (wsel),
      .wdata  (bus_wdata),
      .mask_q (masks[c])
    );
  end

  lvl1_irq_reduce #(.NUM_WORDS(NUM_WORDS), .NUM_CPUS(NUM_CPUS)) u_red (
    .clk    (clk),
    .rst_n  (rst_n),
    .status (status_w),
    .masks  (masks),
    .irq_q  (cpu_irq_o)
  );

  // read mux: strobe groups and unmapped offsets read as zero
  always_comb begin
    rd_data_d = '0;
    if (rd_hit) begin
      case (grp)
        GRP_STATUS: rd_data_d = status_w[wsel];
        GRP_MSTAT:  rd_data_d = masks[bus_cpu][wsel];
        default:    rd_data_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_data_d;
    end
  end
endmodule

// File: rtl/lvl1_irq_agg_chk.sv
module lvl1_irq_agg_chk #(
  parameter int NUM_WORDS = 3,
  parameter int NUM_CPUS  = 2
) (
  input logic                                  clk,
  input logic                                  rst_n,
  input logic [NUM_WORDS*32-1:0]               src_i,
  input logic                                  bus_sel,
  input logic                                  bus_wr,
  input logic                                  rd_valid,
  input logic [NUM_WORDS-1:0][31:0]            status,
  input logic [NUM_CPUS-1:0][NUM_WORDS-1:0][31:0] masks,
  input logic [NUM_CPUS-1:0]                   cpu_irq_o
);
  AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (&masks)); // R1

  AST_STATUS_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (status == $past(src_i))); // R2

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_sel && bus_wr)) |-> (masks == $past(masks))); // R4

  AST_READ_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |=> rd_valid); // R10

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> !rd_valid); // R10

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu_chk
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (&masks[c]) |=> !cpu_irq_o[c]); // R7

    AST_RISE_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_irq_o[c]) |-> $past(|status)); // R7
  end
endmodule

bind lvl1_irq_agg lvl1_irq_agg_chk #(
  .NUM_WORDS (NUM_WORDS),
  .NUM_CPUS  (NUM_CPUS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .src_i     (src_i),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .rd_valid  (rd_valid),
  .status    (status_w),
  .masks     (masks),
  .cpu_irq_o (cpu_irq_o)
);

// File: tb/lvl1_irq_agg_tb.sv
module lvl1_irq_agg_tb;
  localparam int NW = 3;
  localparam int NC = 2;
  localparam int AW = 8;

  logic            clk;
  logic            rst_n;
  logic [NW*32-1:0] src_i;
  logic            bus_sel;
  logic            bus_wr;
  logic [0:0]      bus_cpu;
  logic [AW-1:0]   bus_addr;
  logic [31:0]     bus_wdata;
  logic            rd_valid;
  logic [31:0]     rd_data;
  logic [NC-1:0]   cpu_irq_o;

  lvl1_irq_agg #(.NUM_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_cpu(bus_cpu), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .cpu_irq_o(cpu_irq_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] mdl [NC][NW];
  logic [NW*32-1:0] src_m;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // expected read value from the requirement address map (R3, R9)
  function automatic logic [31:0] exp_read(int cpu, int off);
    int idx = off / 4;
    if ((off % 4) != 0 || idx >= 4 * NW) return 32'h0;
    case (idx / NW)
      0:       return src_m[(idx % NW)*32 +: 32];
      1:       return mdl[cpu][idx % NW];
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [NC-1:0] exp_irq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((src_m[w*32 +: 32] & ~mdl[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  // monitor: pops the scoreboard as read data appears
  logic [31:0] mon_e;
  string       mon_t;
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk("R10 unexpected rd_valid", 32'd1, 32'd0);
      end else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        chk(mon_t, rd_data, mon_e);
      end
    end
  end

  task automatic wr(int cpu, int off, logic [31:0] d);
    int idx = off / 4;
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_cpu = cpu[0]; bus_addr = off[AW-1:0]; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    if ((off % 4) == 0 && idx < 4 * NW) begin
      if (idx / NW == 2) mdl[cpu][idx % NW] = mdl[cpu][idx % NW] | d;
      if (idx / NW == 3) mdl[cpu][idx % NW] = mdl[cpu][idx % NW] & ~d;
    end
  endtask

  task automatic rd(int cpu, int off, string tag);
    exp_q.push_back(exp_read(cpu, off));
    tag_q.push_back(tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_cpu = cpu[0]; bus_addr = off[AW-1:0];
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic rd_all_masks(string tag);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        rd(c, (NW + w) * 4, tag);
  endtask

  task automatic set_src(logic [NW*32-1:0] v);
    @(negedge clk);
    src_i = v; src_m = v;
    @(negedge clk);
  endtask

  // called one edge after a change: output still old, then new
  task automatic irq_step(string tag, logic [NC-1:0] old);
    chk({tag, " irq holds one cycle"}, 32'(cpu_irq_o), 32'(old));
    @(negedge clk);
    chk({tag, " irq updated"}, 32'(cpu_irq_o), 32'(exp_irq()));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    report();
  end

  initial begin
    logic [NC-1:0] old;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_cpu = '0; bus_addr = '0; bus_wdata = '0;
    src_i = {NW{32'hA5A5_0001}}; src_m = src_i;
    for (int c = 0; c < NC; c++) for (int w = 0; w < NW; w++) mdl[c][w] = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R1 irq in reset", 32'(cpu_irq_o), 32'h0);
    chk("R1 rd_valid in reset", 32'(rd_valid), 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 irq after reset", 32'(cpu_irq_o), 32'h0);
    rd_all_masks("R1 R6 reset mask value");

    // R2 R3: status words at their offsets
    set_src({32'h0000_8000, 32'h1234_5678, 32'hDEAD_BEEF});
    for (int w = 0; w < NW; w++) rd(0, w * 4, "R2 R3 status word");
    rd(1, 4, "R2 status same in cpu1 window");
    wr(0, 0, 32'h0);
    rd(0, 0, "R2 status write ignored");

    // R5 R7 R8: unmask one bit in cpu0 word1
    set_src('0);
    old = cpu_irq_o;
    wr(0, (3 * NW + 1) * 4, 32'h0000_0020);
    irq_step("R5 masked clear, no source", old);
    rd(0, (NW + 1) * 4, "R5 mask status after clear");
    @(negedge clk);
    src_i = 96'h0; src_i[32 + 5] = 1'b1; src_m = src_i;
    old = cpu_irq_o;
    @(negedge clk);
    irq_step("R7 R8 source to cpu0 only", old);
    chk("R8 cpu1 stays quiet", 32'(cpu_irq_o[1]), 32'h0);

    // R4: set masks it again
    old = cpu_irq_o;
    wr(0, (2 * NW + 1) * 4, 32'h0000_0020);
    irq_step("R4 set masks source", old);

    // R4 R5 mixed patterns on cpu0 word0
    wr(0, (3 * NW + 0) * 4, 32'h0F0F_0000);
    wr(0, (2 * NW + 0) * 4, 32'h0F00_0000);
    rd(0, NW * 4, "R4 R5 set after clear");
    wr(0, (3 * NW + 0) * 4, 32'h8000_0001);
    rd(0, NW * 4, "R5 clear keeps other bits");

    // R6: writes to mask status ignored
    wr(0, NW * 4, 32'hFFFF_FFFF);
    wr(1, (NW + 2) * 4, 32'h0);
    rd_all_masks("R6 mask status write ignored");

    // R9: unmapped and misaligned offsets
    wr(0, 4 * NW * 4, 32'hFFFF_FFFF);
    wr(1, 8'hFC, 32'hFFFF_FFFF);
    wr(1, (3 * NW) * 4 + 1, 32'hFFFF_FFFF);
    rd_all_masks("R9 unmapped write ignored");
    rd(0, 4 * NW * 4, "R9 first unmapped offset");
    rd(0, 8'hFC, "R9 last offset");
    rd(0, 2, "R9 misaligned read");
    rd(0, (2 * NW) * 4, "R9 strobe group reads zero");

    // R8: route word2 bit0 to cpu1 only
    wr(1, (3 * NW + 2) * 4, 32'h0000_0001);
    rd(0, (NW + 2) * 4, "R8 cpu0 bank untouched");
    rd(1, (NW + 2) * 4, "R8 cpu1 bank cleared");
    old = cpu_irq_o;
    @(negedge clk);
    src_i = 96'h0; src_i[64] = 1'b1; src_m = src_i;
    @(negedge clk);
    irq_step("R7 R8 source to cpu1", old);
    chk("R8 cpu0 not routed", 32'(cpu_irq_o[0]), 32'h0);
    old = cpu_irq_o;
    set_src('0);
    irq_step("R7 source drop", old);

    // R10: rd_valid only after a read
    repeat (3) @(negedge clk);
    chk("R10 rd_valid idle", 32'(rd_valid), 32'h0);
    chk("R10 all reads answered", 32'(exp_q.size()), 32'h0);
    report();
  end
endmodule